// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block is the interrupt-identification side of a bus slave on a shared, wired-AND serial bus. When a local event occurs it latches an alert and pulls the shared active-low alert line. The bus master then reads from the alert response address to learn which slave raised the interrupt. The block answers that query by acknowledging and then returning its own 7-bit address followed by a 1 as the read byte.

Several slaves can answer the same query at once, so the block checks every bit it sends against the bus. If it leaves the line high and sees it low on the rising clock edge, a device with a lower address has won. The block then goes quiet for the rest of the transfer and keeps its alert asserted so that it can try again on a later query. When it sends the whole byte without losing, it drops its alert. It then ignores further queries until a new event arrives.

SCL and SDA come in as samples in the system clock domain and pass through a synchronizer. The only SDA output is a pull-down enable for an open-drain pad.

Top module: `smb_alert_responder`

## Requirements
- R1: A STOP (SDA rising while SCL is high) ends any transfer at any point. It releases SDA and returns the block to idle without changing the alert state.
- R2: When an alert is pending, the received byte 8'b0001_1001 (query address 0001100, then R/W = 1 for read) is acknowledged. The block pulls SDA low for the ninth clock.
- R3: The block does not acknowledge and leaves SDA released for the whole transfer when no alert is pending, when R/W is 0, or when the address differs.
- R4: After acknowledging, the block sends the byte 8'b1100_1001, MSB first: device address 1100100 and then a 1. A 0 bit is sent by pulling SDA low and a 1 bit by releasing it.
- R5: If the block sees SDA low on an SCL rise while it is sending a 1, it stops driving for the rest of that transfer. Its alert stays asserted.
- R6: Sending all eight bits without a loss deasserts the alert output (alert_n_o returns high).
- R7: After a win, later queries are not acknowledged until a new alert event occurs.
- R8: An event pulse drives alert_n_o low when the bus is idle. A pulse that arrives between a START and the following STOP is held and takes effect once that STOP has been seen. This also applies when the pulse coincides with the winning bit.
- R9: sda_pull_o changes only while the synchronized SCL is low.
- R10: The master's ACK or NACK after the sent byte has no effect. SDA stays released until STOP.
- R11: A repeated START abandons any partly received byte and starts a new address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| alert_evt_i | input | 1 | One-cycle alert event pulse |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| alert_n_o | output | 1 | Active-low alert, 0 = asserted |

## Verification
A new alert event and the arbitration win both write the same alert latch. A win clears it while the event must keep it set. The bench repeats a winning query several times and moves the event pulse one system clock at a time across the window around the final bit's rising edge, so that in one pass the pulse and the clearing fall in the same cycle. The behavioural model predicts that the alert is clear right after the win and is set again once STOP is seen. The comparison on every clock judges both the cleared state before STOP and the reasserted state after it.

// File: rtl/alrsp_pkg.sv
`timescale 1ns/1ps
package alrsp_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_WAIT,
        ST_ACK_DRV,
        ST_TX,
        ST_WAIT_STOP
    } resp_state_t;

    // Synchronized bus view and the events derived from it.
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic scl;
        logic sda;
    } bus_ev_t;

    // A 7-bit address followed by the read flag (1).
    function automatic logic [BYTE_W-1:0] addr_rd(input logic [6:0] a);
        return {a, 1'b1};
    endfunction

endpackage

// File: rtl/alrsp_sync.sv
`timescale 1ns/1ps
module alrsp_sync
    import alrsp_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    // STAGES must be at least 2.
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_q, sda_q;
    logic              scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_q  <= scl_sh[STAGES-1];
            sda_q  <= sda_sh[STAGES-1];
        end
    end

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    always_comb begin
        ev_o.scl      = scl_s;
        ev_o.sda      = sda_s;
        ev_o.scl_rise = scl_s & ~scl_q;
        ev_o.scl_fall = ~scl_s & scl_q;
        ev_o.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/alrsp_fsm.sv
`timescale 1ns/1ps
module alrsp_fsm
    import alrsp_pkg::*;
#(
    parameter logic [6:0] QUERY_ADDR = 7'b0001100,
    parameter logic [6:0] OWN_ADDR   = 7'b1100100
) (
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev_i,
    input  logic    alert_i,
    output logic    sda_pull_o,
    output logic    busy_o,
    output logic    win_o
);
    localparam logic [BYTE_W-1:0] MATCH_BYTE = addr_rd(QUERY_ADDR);
    localparam logic [BYTE_W-1:0] TX_BYTE    = addr_rd(OWN_ADDR);
    localparam logic [CNT_W-1:0]  LAST_BIT   = CNT_W'(BYTE_W - 1);

    resp_state_t       state;
    logic [CNT_W-1:0]  cnt, cnt_nxt;
    logic [BYTE_W-1:0] shreg, rx_byte;
    logic              tx_bit, lost_now;

    assign cnt_nxt  = cnt + 1'b1;
    assign rx_byte  = {shreg[BYTE_W-2:0], ev_i.sda};
    assign tx_bit   = TX_BYTE[LAST_BIT - cnt];
    assign lost_now = tx_bit & ~ev_i.sda;
    assign win_o    = (state == ST_TX) & ev_i.scl_rise & ~lost_now & (cnt == LAST_BIT);
    assign busy_o   = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            shreg      <= '0;
            sda_pull_o <= 1'b0;
        end else if (ev_i.stop) begin
            state      <= ST_IDLE;
            sda_pull_o <= 1'b0;
        end else if (ev_i.start) begin
            state      <= ST_RX;
            cnt        <= '0;
            sda_pull_o <= 1'b0;
        end else begin
            unique case (state)
                ST_RX: if (ev_i.scl_rise) begin
                    shreg <= rx_byte;
                    cnt   <= cnt_nxt;
                    if (cnt == LAST_BIT)
                        state <= (rx_byte == MATCH_BYTE && alert_i) ? ST_ACK_WAIT : ST_WAIT_STOP;
                end
                ST_ACK_WAIT: if (ev_i.scl_fall) begin
                    sda_pull_o <= 1'b1;
                    state      <= ST_ACK_DRV;
                end
                ST_ACK_DRV: if (ev_i.scl_fall) begin
                    sda_pull_o <= ~TX_BYTE[BYTE_W-1];
                    cnt        <= '0;
                    state      <= ST_TX;
                end
                ST_TX: begin
                    if (ev_i.scl_rise && (lost_now || cnt == LAST_BIT))
                        state <= ST_WAIT_STOP;
                    else if (ev_i.scl_fall) begin
                        cnt        <= cnt_nxt;
                        sda_pull_o <= ~TX_BYTE[LAST_BIT - cnt_nxt];
                    end
                end
                default: ;
            endcase
        end
    end

    // R9: a new pull-down begins only on a falling SCL edge.
    a_r9_pull_on_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> $past(ev_i.scl_fall));

    // R1: a STOP leaves the block idle with SDA released.
    a_r1_stop_idles: assert property (@(posedge clk) disable iff (rst)
        $past(ev_i.stop) |-> (!busy_o && !sda_pull_o));

    // R2: an acknowledge is only driven while the alert latch is set.
    a_r2_ack_needs_alert: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACK_DRV) |-> alert_i);

endmodule

// File: rtl/alrsp_alert.sv
`timescale 1ns/1ps
module alrsp_alert (
    input  logic clk,
    input  logic rst,
    input  logic evt_i,
    input  logic busy_i,
    input  logic win_i,
    output logic alert_o
);
    logic pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            alert_o <= 1'b0;
            pend    <= 1'b0;
        end else begin
            if (win_i)
                alert_o <= 1'b0;
            if (evt_i) begin
                if (busy_i) pend <= 1'b1;
                else        alert_o <= 1'b1;
            end
            if (!busy_i && pend) begin
                alert_o <= 1'b1;
                pend    <= 1'b0;
            end
        end
    end

    // R6: the alert only clears after a winning byte.
    a_r6_clear_on_win: assert property (@(posedge clk) disable iff (rst)
        $fell(alert_o) |-> $past(win_i));

    // R8: the alert is never raised in the middle of a transfer.
    a_r8_set_when_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(alert_o) |-> !$past(busy_i));

endmodule

// File: rtl/smb_alert_responder.sv
`timescale 1ns/1ps
module smb_alert_responder
    import alrsp_pkg::*;
#(
    parameter logic [6:0] QUERY_ADDR  = 7'b0001100,
    parameter logic [6:0] OWN_ADDR    = 7'b1100100,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic alert_evt_i,
    output logic sda_pull_o,
    output logic alert_n_o
);
    bus_ev_t ev;
    logic    alert, busy, win;

    alrsp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    alrsp_fsm #(.QUERY_ADDR(QUERY_ADDR), .OWN_ADDR(OWN_ADDR)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ev_i       (ev),
        .alert_i    (alert),
        .sda_pull_o (sda_pull_o),
        .busy_o     (busy),
        .win_o      (win)
    );

    alrsp_alert u_alert (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (alert_evt_i),
        .busy_i  (busy),
        .win_i   (win),
        .alert_o (alert)
    );

    assign alert_n_o = ~alert;

    // R10: SDA stays released while the sequencer waits for STOP.
    a_r10_released_after_win: assert property (@(posedge clk) disable iff (rst)
        $past(win) |-> !sda_pull_o);

endmodule

// File: tb/smb_alert_responder_tb.sv
`timescale 1ns/1ps
module smb_alert_responder_tb_top;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1, m_sda = 1'b1, oth = 1'b1, evt = 1'b0;
    logic sda_pull, alert_n;
    wire  sda_line = m_sda & oth & ~sda_pull;

    always #2.5 clk = ~clk;

    smb_alert_responder dut_i (
        .clk (clk), .rst (rst), .scl_i (m_scl), .sda_i (sda_line),
        .alert_evt_i (evt), .sda_pull_o (sda_pull), .alert_n_o (alert_n)
    );

    // Behavioural reference: 0 idle, 1 receiving, 2 ack due, 3 acking,
    // 4 sending, 6 waiting for STOP.
    int    mst = 0, nbits = 0, acc = 0, txi = 0;
    bit    ref_pull = 0, ref_alert = 0, pend = 0;
    int    settle = 4;
    int    checks = 0, fails = 0;
    bit    done = 0;
    bit    prev_pull = 0;
    string cur_req = "R8";
    localparam int TXB = 8'hC9;

    function automatic bit mline();
        return m_sda & oth & ~ref_pull;
    endfunction

    task automatic model_bus(bit os, bit ol, bit ns, bit nl);
        if (os && ns) begin
            if (ol && !nl) begin
                mst = 1; nbits = 0; acc = 0; ref_pull = 0;
            end else if (!ol && nl) begin
                if (mst != 0 && pend) begin ref_alert = 1; pend = 0; end
                mst = 0; ref_pull = 0;
            end
        end else if (!os && ns) begin
            if (mst == 1) begin
                acc = ((acc << 1) | int'(nl)) & 255;
                nbits++;
                if (nbits == 8) mst = (acc == 8'h19 && ref_alert) ? 2 : 6;
            end else if (mst == 4) begin
                if (((TXB >> (7 - txi)) & 1) == 1 && !nl) mst = 6;
                else if (txi == 7) begin ref_alert = 0; mst = 6; end
            end
        end else if (os && !ns) begin
            if (mst == 2) begin ref_pull = 1; mst = 3; end
            else if (mst == 3) begin txi = 0; ref_pull = ((TXB >> 7) & 1) == 0; mst = 4; end
            else if (mst == 4) begin txi++; ref_pull = ((TXB >> (7 - txi)) & 1) == 0; end
        end
    endtask

    task automatic model_evt();
        if (mst != 0) pend = 1; else ref_alert = 1;
        settle = 6;
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            if (settle > 0) settle--;
            else begin
                checks++;
                if (sda_pull !== ref_pull || alert_n !== !ref_alert) begin
                    fails++;
                    $display("FAIL %s: pull=%b alert_n=%b expected pull=%b alert_n=%b",
                             cur_req, sda_pull, alert_n, ref_pull, !ref_alert);
                end
                if (m_scl) begin
                    checks++;
                    if (sda_pull !== prev_pull) begin
                        fails++;
                        $display("FAIL R9: pull=%b while SCL high, expected %b", sda_pull, prev_pull);
                    end
                end
            end
            prev_pull = sda_pull;
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus(bit s, bit d, int evk = -1);
        bit os, ol, nl;
        @(posedge clk); #1;
        os = m_scl; ol = mline();
        m_scl = s; m_sda = d;
        nl = mline();
        model_bus(os, ol, s, nl);
        settle = 6;
        for (int c = 0; c < HALF; c++) begin
            @(posedge clk); #1;
            evt = (c == evk);
            if (c == evk) model_evt();
        end
    endtask

    task automatic pulse_evt();
        @(posedge clk); #1; evt = 1; model_evt();
        @(posedge clk); #1; evt = 0;
        repeat (8) @(posedge clk);
    endtask

    task automatic start_c();  bus(1, 1); bus(1, 0); bus(0, 0); endtask
    task automatic rstart_c(); bus(0, 1); bus(1, 1); bus(1, 0); bus(0, 0); endtask
    task automatic stop_c();   bus(0, 0); bus(1, 0); bus(1, 1); endtask
    task automatic wbit(bit b); bus(0, b); bus(1, b); bus(0, b); endtask

    task automatic send_byte(logic [7:0] v, bit exp_ack, string req);
        bit got;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        bus(0, 1); bus(1, 1);
        got = sda_line;
        chk(got == exp_ack, req, got, exp_ack);
        bus(0, 1);
    endtask

    task automatic read_byte(logic [7:0] opat, bit mack, logic [7:0] exp, string req, int evk);
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) begin
            oth = opat[i];
            bus(0, 1);
            bus(1, 1, (i == 0) ? evk : -1);
            got[i] = sda_line;
            bus(0, 1);
        end
        oth = 1;
        wbit(mack);
        chk(got == exp, req, got, exp);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 0;
        repeat (6) @(posedge clk);
        chk(alert_n === 1'b1 && sda_pull === 1'b0, "R8 reset state", {alert_n, sda_pull}, 2'b10);

        cur_req = "R3";
        start_c(); send_byte(8'h19, 1, "R3 no alert"); stop_c();

        cur_req = "R8";
        pulse_evt();
        chk(alert_n == 0, "R8 idle event", alert_n, 0);

        cur_req = "R3";
        start_c(); send_byte(8'h18, 1, "R3 write bit"); stop_c();
        start_c(); send_byte(8'hC9, 1, "R3 other address"); stop_c();

        cur_req = "R5";
        start_c(); send_byte(8'h19, 0, "R2 ack");
        read_byte(8'h91, 1, 8'h91, "R5 lost byte", -1);
        stop_c();
        chk(alert_n == 0, "R5 alert kept", alert_n, 0);

        cur_req = "R4";
        start_c(); send_byte(8'h19, 0, "R2 retry ack");
        read_byte(8'hFF, 0, 8'hC9, "R4 own byte, R10 master ack", -1);
        chk(alert_n == 1, "R6 cleared", alert_n, 1);
        stop_c();

        cur_req = "R7";
        start_c(); send_byte(8'h19, 1, "R7 ignored"); stop_c();

        cur_req = "R8";
        pulse_evt();
        for (int k = 0; k < 6; k++) begin
            start_c(); send_byte(8'h19, 0, "R2 sweep ack");
            read_byte(8'hFF, 1, 8'hC9, "R6 sweep win", k);
            stop_c();
            chk(alert_n == 0, "R8 deferred event", alert_n, 0);
        end

        cur_req = "R11";
        start_c(); wbit(1); wbit(0); wbit(1);
        rstart_c(); send_byte(8'h19, 0, "R11 restart ack");
        cur_req = "R1";
        bus(0, 1); bus(1, 1);
        chk(sda_line == 1, "R1 first bit", sda_line, 1);
        bus(0, 1);
        stop_c();
        chk(sda_pull == 0 && alert_n == 0, "R1 stop abort", {sda_pull, alert_n}, 2'b00);

        cur_req = "R6";
        start_c(); send_byte(8'h19, 0, "R2 final ack");
        read_byte(8'hFF, 1, 8'hC9, "R4 final byte", -1);
        stop_c();
        chk(alert_n == 1, "R6 final clear", alert_n, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule